// File: doc/BRIEF.md
# Vector-Input Polyphase FIR Decimator

This block filters a stream of signed samples with a fixed FIR response and keeps one filtered sample out of every `DECIM`. Each clock cycle the block may accept a vector of `LANES` samples. Lane 0 holds the oldest sample of the vector. An input valid flag marks which cycles carry data. A synchronous clear abandons any result in progress and empties the filter history. The coefficients, the lane count, the decimation factor and all widths are parameters.

The block has two forms, and the parameters choose one at elaboration. If the vector is narrower than the decimation factor (`DECIM` a multiple of `LANES`), each lane drives its own multiplier row. Each row steps through `DECIM/LANES` coefficient sets in turn and adds into a small bank of partial sums. A single scalar result leaves the block once per group of `DECIM/LANES` accepted vectors. If the vector is at least as wide as the decimation factor (`LANES` a multiple of `DECIM`), the block keeps a window of past samples. It then produces `LANES/DECIM` results from every accepted vector, and result 0 is the earliest in time.

The model of correct behaviour is simple. Flatten the input vectors into one scalar stream. Filter that stream with the full coefficient set, y[n] = sum over k of h[k]·x[n−k], where samples before the start of the stream count as zero. Then keep y[n] for every n with n mod `DECIM` = `DECIM`−1.

Top module: `fir_vec_decim`

## Requirements
- R1: While and after `rst_n` is low, and until the first accepted input completes a result, `out_valid` is low.
- R2: With `LANES` < `DECIM`, `out_valid` is high for exactly one cycle. That cycle is the one after the clock edge that accepts the (`DECIM/LANES`)-th vector of each group. Groups are counted from reset or clear. `out_valid` is low in every other cycle.
- R3: With `LANES` < `DECIM`, the m-th result, counted from 0, equals y[m·DECIM + DECIM−1] of the flattened stream. Input lane i sits at `in_data[i*DATA_W +: DATA_W]`, and lane 0 is the oldest sample.
- R4: With `LANES` ≥ `DECIM`, `out_valid` is high in the cycle after every accepted vector and low otherwise.
- R5: With `LANES` ≥ `DECIM`, output element j at `out_data[j*OUT_W +: OUT_W]` from accepted vector t equals y[t·LANES + j·DECIM + DECIM−1].
- R6: Coefficient k is taken from `COEF[k*COEF_W +: COEF_W]`. Positions at or beyond `TAPS` contribute zero, so an impulse yields h[k] at the kept positions and zero past the last tap, also when `TAPS` is not a multiple of `DECIM`.
- R7: A cycle with `in_valid` low ignores `in_data`. It produces no result and does not advance the group position or the sample history.
- R8: `clear` high overrides `in_valid`. It drops any partial result and zeroes the history. The next cycle shows no result, and the next accepted vector starts a new stream at index 0.
- R9: Results carry full precision in `OUT_W` = `DATA_W`+`COEF_W`+ceil(log2 `TAPS`) bits and do not wrap for any input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of history and partial results |
| in_valid | input | 1 | Input vector is present this cycle |
| in_data | input | LANES*DATA_W | Signed samples; lane 0 is the oldest |
| out_valid | output | 1 | Output carries a result this cycle |
| out_data | output | OUT_LANES*OUT_W | Signed results; element 0 is the earliest (OUT_LANES = LANES/DECIM when LANES ≥ DECIM, else 1) |

## Verification
Every result is registered once, so it appears in the cycle after the clock edge that accepts the input that completes it. In narrow mode that input is the last vector of a group. In wide mode it is every accepted vector. Before each edge the bench computes the expected flag and values from a scalar filter-then-decimate model. It compares them at the following falling edge, exactly one cycle after the stimulus. Cycles with no input and clear cycles are scored the same way, with the expected flag low on the next cycle.

// File: rtl/fir_dec_pkg.sv
package fir_dec_pkg;

    // Integer division rounded up.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Width that holds a full-precision sum of n products.
    function automatic int full_width(input int dw, input int cw, input int n);
        return dw + cw + ((n > 1) ? $clog2(n) : 1);
    endfunction

endpackage

// File: rtl/fir_dec_narrow.sv
module fir_dec_narrow
    import fir_dec_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DECIM  = 8,
    parameter int TAPS   = 11,
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int OUT_W  = 20,
    parameter logic [TAPS*COEF_W-1:0] COEF = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      in_valid,
    input  logic [LANES*DATA_W-1:0]   in_data,
    output logic                      out_valid,
    output logic [OUT_W-1:0]          out_data
);
    localparam int SETS = DECIM / LANES;
    localparam int BANK = ceil_div(TAPS, DECIM);
    localparam int PH_W = (SETS > 1) ? $clog2(SETS) : 1;

    logic [PH_W-1:0]          phase;
    logic signed [OUT_W-1:0]  acc  [BANK];
    logic signed [OUT_W-1:0]  step [BANK];
    logic signed [OUT_W-1:0]  nxt  [BANK];
    logic                     last_set;

    function automatic logic signed [COEF_W-1:0] coef_at(input int idx);
        if (idx < 0 || idx >= TAPS) return '0;
        return COEF[idx*COEF_W +: COEF_W];
    endfunction

    assign last_set = (phase == PH_W'(SETS - 1));

    // Each lane multiplies by the coefficient that its position in the
    // group selects, for every result still being built.
    always_comb begin
        for (int j = 0; j < BANK; j++) begin
            step[j] = '0;
            for (int i = 0; i < LANES; i++) begin
                step[j] = step[j] + OUT_W'(
                    coef_at(j*DECIM + DECIM - 1 - int'(phase)*LANES - i)
                    * $signed(in_data[i*DATA_W +: DATA_W]));
            end
            nxt[j] = acc[j] + step[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            for (int j = 0; j < BANK; j++) acc[j] <= '0;
        end else if (clear) begin
            phase     <= '0;
            out_valid <= 1'b0;
            for (int j = 0; j < BANK; j++) acc[j] <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                if (last_set) begin
                    phase     <= '0;
                    out_valid <= 1'b1;
                    out_data  <= nxt[0];
                    for (int j = 0; j < BANK - 1; j++) acc[j] <= nxt[j+1];
                    acc[BANK-1] <= '0;
                end else begin
                    phase <= phase + PH_W'(1);
                    for (int j = 0; j < BANK; j++) acc[j] <= nxt[j];
                end
            end
        end
    end

    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase) < SETS);

    assert_result_follows_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && !clear));

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clear) |=> ($stable(phase) && !out_valid));

    assert_clear_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!out_valid && phase == '0));

    generate
        if (SETS > 1) begin : g_spacing
            assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |=> !out_valid);
        end
    endgenerate

endmodule

// File: rtl/fir_dec_wide.sv
module fir_dec_wide
    import fir_dec_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int DECIM  = 4,
    parameter int TAPS   = 11,
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int OUT_W  = 20,
    parameter logic [TAPS*COEF_W-1:0] COEF = '0,
    localparam int OUT_LANES = LANES / DECIM
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          in_valid,
    input  logic [LANES*DATA_W-1:0]       in_data,
    output logic                          out_valid,
    output logic [OUT_LANES*OUT_W-1:0]    out_data
);
    localparam int HIST = (TAPS > 1) ? TAPS - 1 : 1;
    localparam int WIN  = HIST + LANES;

    logic [HIST*DATA_W-1:0]   hist;
    logic [WIN*DATA_W-1:0]    win;
    logic signed [OUT_W-1:0]  res [OUT_LANES];

    function automatic logic signed [COEF_W-1:0] coef_at(input int idx);
        if (idx < 0 || idx >= TAPS) return '0;
        return COEF[idx*COEF_W +: COEF_W];
    endfunction

    // Window index 0 is the oldest sample; the new vector sits on top.
    assign win = {in_data, hist};

    always_comb begin
        for (int j = 0; j < OUT_LANES; j++) begin
            res[j] = '0;
            for (int k = 0; k < TAPS; k++) begin
                res[j] = res[j] + OUT_W'(coef_at(k)
                    * $signed(win[(HIST + j*DECIM + DECIM - 1 - k)*DATA_W +: DATA_W]));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (clear) begin
            hist      <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                hist <= win[LANES*DATA_W +: HIST*DATA_W];
                for (int j = 0; j < OUT_LANES; j++) out_data[j*OUT_W +: OUT_W] <= res[j];
            end
        end
    end

    assert_idle_keeps_history_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clear) |=> ($stable(hist) && !out_valid));

    assert_every_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clear) |=> out_valid);

    assert_clear_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!out_valid && hist == '0));

endmodule

// File: rtl/fir_vec_decim.sv
module fir_vec_decim
    import fir_dec_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DECIM  = 8,
    parameter int TAPS   = 11,
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter logic [TAPS*COEF_W-1:0] COEF = {
        8'sd2, -8'sd4, 8'sd9, -8'sd22, 8'sd38, 8'sd61,
        -8'sd43, 8'sd27, 8'sd14, -8'sd9, 8'sd5},
    localparam int OUT_W     = full_width(DATA_W, COEF_W, TAPS),
    localparam int OUT_LANES = (LANES >= DECIM) ? LANES / DECIM : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          in_valid,
    input  logic [LANES*DATA_W-1:0]       in_data,
    output logic                          out_valid,
    output logic [OUT_LANES*OUT_W-1:0]    out_data
);

    generate
        if (LANES < DECIM) begin : g_narrow
            fir_dec_narrow #(
                .LANES(LANES), .DECIM(DECIM), .TAPS(TAPS),
                .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .COEF(COEF)
            ) i_narrow (
                .clk(clk), .rst_n(rst_n), .clear(clear),
                .in_valid(in_valid), .in_data(in_data),
                .out_valid(out_valid), .out_data(out_data)
            );
        end else begin : g_wide
            fir_dec_wide #(
                .LANES(LANES), .DECIM(DECIM), .TAPS(TAPS),
                .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .COEF(COEF)
            ) i_wide (
                .clk(clk), .rst_n(rst_n), .clear(clear),
                .in_valid(in_valid), .in_data(in_data),
                .out_valid(out_valid), .out_data(out_data)
            );
        end
    endgenerate

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: tb/test_fir_vec_decim.sv
`timescale 1ns/1ps
module test_fir_vec_decim;

    localparam int TAPS = 11;
    localparam int DW   = 8;
    localparam int CW   = 8;
    localparam int OW   = DW + CW + 4;
    localparam int VN   = 2;   // narrow instance lanes
    localparam int RN   = 6;   // narrow instance decimation
    localparam int VW   = 8;   // wide instance lanes
    localparam int RW   = 4;   // wide instance decimation
    localparam int OLW  = VW / RW;
    localparam logic [TAPS*CW-1:0] CF = {
        8'sd2, -8'sd4, 8'sd9, -8'sd22, 8'sd38, 8'sd61,
        -8'sd43, 8'sd27, 8'sd14, -8'sd9, 8'sd5};
    localparam int H [TAPS] = '{5, -9, 14, 27, -43, 61, 38, -22, 9, -4, 2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic vld = 1'b0;
    logic [VN*DW-1:0]   di = '0;
    logic [VW*DW-1:0]   dw = '0;
    logic               oi_v;
    logic [OW-1:0]      oi_d;
    logic               ow_v;
    logic [OLW*OW-1:0]  ow_d;

    always #5 clk = ~clk;

    fir_vec_decim #(.LANES(VN), .DECIM(RN), .TAPS(TAPS), .DATA_W(DW), .COEF_W(CW), .COEF(CF))
    i_fir_vec_decim (
        .clk(clk), .rst_n(rst_n), .clear(clr), .in_valid(vld), .in_data(di),
        .out_valid(oi_v), .out_data(oi_d));

    fir_vec_decim #(.LANES(VW), .DECIM(RW), .TAPS(TAPS), .DATA_W(DW), .COEF_W(CW), .COEF(CF))
    i_fir_vec_decim_wide (
        .clk(clk), .rst_n(rst_n), .clear(clr), .in_valid(vld), .in_data(dw),
        .out_valid(ow_v), .out_data(ow_d));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int xi [4096];
    int xw [4096];
    int ni = 0;
    int nw = 0;
    int pat = 0;   // 0 random, 1 impulse, 2 extremes

    bit     pend = 0;
    bit     e_iv, e_wv;
    longint e_id;
    longint e_wd [OLW];
    string  t_flag_i, t_flag_w, t_data_i, t_data_w;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint gold(input bit wide, input int n);
        longint s = 0;
        for (int k = 0; k < TAPS; k++) begin
            if (n - k >= 0) s += longint'(H[k]) * longint'(wide ? xw[n-k] : xi[n-k]);
        end
        return s;
    endfunction

    function automatic int pick(input int idx);
        if (pat == 1) return (idx == 0) ? 100 : 0;
        if (pat == 2) return ($urandom_range(1) == 1) ? 127 : -128;
        return int'($urandom_range(255)) - 128;
    endfunction

    task automatic score();
        if (!pend) return;
        chk(t_flag_i, "narrow out_valid", longint'(oi_v), longint'(e_iv));
        if (e_iv) chk(t_data_i, "narrow out_data", longint'($signed(oi_d)), e_id);
        chk(t_flag_w, "wide out_valid", longint'(ow_v), longint'(e_wv));
        if (e_wv) begin
            for (int j = 0; j < OLW; j++)
                chk(t_data_w, $sformatf("wide out_data[%0d]", j),
                    longint'($signed(ow_d[j*OW +: OW])), e_wd[j]);
        end
    endtask

    // One cycle: score the previous stimulus, then drive the next one.
    task automatic step(input bit v, input bit c, input string tfi, input string tdi,
                        input string tfw, input string tdw);
        int s;
        @(negedge clk);
        score();
        vld = v;
        clr = c;
        t_flag_i = tfi; t_data_i = tdi; t_flag_w = tfw; t_data_w = tdw;
        if (c) begin
            ni = 0; nw = 0; e_iv = 0; e_wv = 0;
        end
        for (int e = 0; e < VN; e++) begin
            s = (v && !c) ? pick(ni + e) : int'($urandom_range(255)) - 128;
            di[e*DW +: DW] = DW'(s);
            if (v && !c) xi[ni + e] = s;
        end
        for (int e = 0; e < VW; e++) begin
            s = (v && !c) ? pick(nw + e) : int'($urandom_range(255)) - 128;
            dw[e*DW +: DW] = DW'(s);
            if (v && !c) xw[nw + e] = s;
        end
        if (!c) begin
            if (v) begin
                ni += VN;
                e_iv = (ni % RN) == 0;
                e_id = gold(1'b0, ni - 1);
                for (int j = 0; j < OLW; j++) e_wd[j] = gold(1'b1, nw + j*RW + RW - 1);
                nw += VW;
                e_wv = 1;
            end else begin
                e_iv = 0; e_wv = 0;
            end
        end
        pend = 1;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1", "narrow out_valid in reset", longint'(oi_v), 0);
        chk("R1", "wide out_valid in reset", longint'(ow_v), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "narrow out_valid after reset", longint'(oi_v), 0);
        chk("R1", "wide out_valid after reset", longint'(ow_v), 0);

        // Impulse response after a clear: zero padding beyond the last tap
        step(0, 1, "R8", "R8", "R8", "R8");
        pat = 1;
        for (int c = 0; c < 14; c++) step(1, 0, "R6", "R6", "R6", "R6");

        // Contiguous random vectors
        pat = 0;
        for (int c = 0; c < 45; c++) step(1, 0, "R2", "R3", "R4", "R5");

        // Random gaps in the input valid flag
        for (int c = 0; c < 60; c++)
            step(bit'($urandom_range(1)), 0, "R7", "R7", "R7", "R7");

        // Clear in the middle of a narrow group, with valid held high
        step(1, 0, "R8", "R8", "R8", "R8");
        step(1, 1, "R8", "R8", "R8", "R8");
        for (int c = 0; c < 20; c++) step(1, 0, "R8", "R8", "R8", "R8");

        // Extreme sample values
        pat = 2;
        for (int c = 0; c < 36; c++) step(1, 0, "R9", "R9", "R9", "R9");

        pat = 0;
        step(0, 0, "R7", "R7", "R7", "R7");
        step(0, 0, "R7", "R7", "R7", "R7");
        @(negedge clk);
        score();
        pend = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule